// File: doc/BRIEF.md
# Fractal Pixel Task Dispatcher

This block feeds a bank of parallel escape-time iteration cores and gathers their answers into a frame store. It walks the frame in raster order and turns every pixel into a complex-plane point using an origin and a per-pixel step. The point, together with its pixel coordinates, is queued in a task FIFO. Each cycle, the head of that queue goes to the lowest-numbered core that reports itself free. Every core hands its result, which is the pixel coordinates plus an iteration count, into a FIFO of its own. A collector visits the non-empty result FIFOs in rotating order. It writes one 16-bit word per cycle to a single-port memory, with no read-modify-write.

Pan and zoom commands move the origin or rescale the step, then restart the frame from the first pixel. Any tasks still queued from the old frame are discarded at that point. Tasks already inside a core still finish and are written; the new frame overwrites them later. The iteration cores themselves are outside the block.

Top module: `fractal_dispatch`

## Requirements
- R1: While reset is high, `sram_we` and every bit of `core_task_valid` are 0. Reset loads the origin and step from parameters and starts a frame at pixel (0,0).
- R2: Tasks leave in raster order: x rises from 0 to HRES-1, then y advances. The point for pixel (x,y) is re = origin_re + x*step and im = origin_im + y*step, in 36-bit two's complement. Core slice i of `core_task_data` is bits [i*92 +: 92], laid out as {x[91:82], y[81:72], re[71:36], im[35:0]}.
- R3: When the task queue is non-empty and at least one core is ready, exactly one task is issued in that same cycle. No more than one task is issued per cycle. With all cores free, a full frame is issued within HRES*VRES+12 cycles of a command.
- R4: A task goes to the lowest-indexed core whose `core_ready` bit is high.
- R5: When no core is ready, the head task waits in the queue. It is neither lost nor reordered.
- R6: Each core has its own result FIFO. `core_res_ready[i]` is low only while that FIFO is full. A result offered while ready is low is held off and is not lost. Result slice i is bits [i*36 +: 36], laid out as {x[35:26], y[25:16], iter[15:0]}.
- R7: The collector writes at most one word per cycle. Non-empty result FIFOs are served in rotating order. Each write has address y*HRES + x and data equal to the iteration count, and is issued one cycle after its FIFO entry is taken.
- R8: For a frame that runs to completion, every pixel address receives exactly one write.
- R9: Pan commands shift the origin by step*2^PAN_SHIFT. Code 0 subtracts from re, 1 adds to re, 2 subtracts from im, and 3 adds to im.
- R10: Code 4 zooms in: the step is halved (arithmetic shift) and origin += (HRES/4, VRES/4)*old step. Code 5 zooms out: the step is doubled and origin -= (HRES/2, VRES/2)*old step. Code 4 at a step of 1 is ignored.
- R11: Codes 6 and 7 are ignored. They start no frame and change neither origin nor step.
- R12: An accepted command flushes the task queue. The next task issued is pixel (0,0) of the new view, even if the command arrives mid-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Pan/zoom command strobe |
| cmd_code | input | 3 | Command code (see R9 to R11) |
| core_task_valid | output | NCORES | One-hot task issue, one bit per core |
| core_task_data | output | NCORES*92 | Task word for each core (head of queue, broadcast) |
| core_ready | input | NCORES | Core is free to take a task |
| core_res_valid | input | NCORES | Core offers a result |
| core_res_data | input | NCORES*36 | Result word for each core |
| core_res_ready | output | NCORES | Result FIFO of that core has room |
| sram_we | output | 1 | Memory write strobe |
| sram_addr | output | $clog2(HRES*VRES) | Pixel word address |
| sram_wdata | output | 16 | Iteration count written |

## Verification
Three kinds of internal fault show up quickly at the ports. A scan counter or accumulator that drifts gives a wrong coordinate or an out-of-order pixel on the very next accepted task. A wrong priority pick shows as a valid bit on a core above a lower ready core in that same cycle. A result FIFO pointer or rotation fault surfaces later, when the frame has drained: the write count for some address is zero or two, or a word carries the wrong count. A stale origin or step after a command shows in the first task of the new frame, and an ignored code that wrongly restarts shows as tasks appearing within a few cycles.

// File: rtl/fd_pkg.sv
package fd_pkg;

    localparam int XW = 10;
    localparam int YW = 10;
    localparam int CW = 36;
    localparam int IW = 16;

    typedef logic signed [CW-1:0] coord_t;

    typedef struct packed {
        logic [XW-1:0] x;
        logic [YW-1:0] y;
        coord_t        re;
        coord_t        im;
    } task_t;

    typedef struct packed {
        logic [XW-1:0] x;
        logic [YW-1:0] y;
        logic [IW-1:0] iter;
    } result_t;

    typedef enum logic [2:0] {
        CMD_LEFT  = 3'd0,
        CMD_RIGHT = 3'd1,
        CMD_UP    = 3'd2,
        CMD_DOWN  = 3'd3,
        CMD_ZIN   = 3'd4,
        CMD_ZOUT  = 3'd5
    } cmd_e;

    function automatic logic cmd_known(input logic [2:0] code);
        return code <= 3'd5;
    endfunction

endpackage

// File: rtl/fd_fifo.sv
module fd_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [CNTW-1:0]  cnt;
    logic             do_push, do_pop;

    assign full    = (cnt == CNTW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            cnt <= cnt + CNTW'(do_push) - CNTW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    assert_pop_nonempty_R5: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty) else $error("pop while empty");

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !flush) |=> full) else $error("full fifo lost its level");

    assert_flush_empties_R12: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty) else $error("flush left entries");

endmodule

// File: rtl/fd_scan.sv
module fd_scan
    import fd_pkg::*;
#(
    parameter int     HRES      = 1024,
    parameter int     VRES      = 768,
    parameter int     PAN_SHIFT = 4,
    parameter coord_t INIT_RE   = -36'sd17179869184,
    parameter coord_t INIT_IM   = -36'sd9663676416,
    parameter coord_t INIT_STEP = 36'sd25165824
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_code,
    input  logic       q_full,
    output logic       push,
    output task_t      task_out,
    output logic       restart
);
    coord_t        org_re, org_im, step;
    coord_t        acc_re, acc_im;
    coord_t        n_re, n_im, n_step, pan;
    logic [XW-1:0] x;
    logic [YW-1:0] y;
    logic          active;

    assign pan     = step <<< PAN_SHIFT;
    assign restart = cmd_valid && cmd_known(cmd_code)
                     && !(cmd_code == CMD_ZIN && step == coord_t'(1));
    assign push    = active && !q_full;
    assign task_out = '{x: x, y: y, re: acc_re, im: acc_im};

    always_comb begin
        n_re   = org_re;
        n_im   = org_im;
        n_step = step;
        case (cmd_code)
            CMD_LEFT:  n_re = org_re - pan;
            CMD_RIGHT: n_re = org_re + pan;
            CMD_UP:    n_im = org_im - pan;
            CMD_DOWN:  n_im = org_im + pan;
            CMD_ZIN: begin
                n_step = step >>> 1;
                n_re   = org_re + step * coord_t'(HRES / 4);
                n_im   = org_im + step * coord_t'(VRES / 4);
            end
            CMD_ZOUT: begin
                n_step = step <<< 1;
                n_re   = org_re - step * coord_t'(HRES / 2);
                n_im   = org_im - step * coord_t'(VRES / 2);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            org_re <= INIT_RE;
            org_im <= INIT_IM;
            step   <= INIT_STEP;
            acc_re <= INIT_RE;
            acc_im <= INIT_IM;
            x      <= '0;
            y      <= '0;
            active <= 1'b1;
        end else if (restart) begin
            org_re <= n_re;
            org_im <= n_im;
            step   <= n_step;
            acc_re <= n_re;
            acc_im <= n_im;
            x      <= '0;
            y      <= '0;
            active <= 1'b1;
        end else if (push) begin
            if (x == XW'(HRES - 1)) begin
                x      <= '0;
                acc_re <= org_re;
                if (y == YW'(VRES - 1)) begin
                    active <= 1'b0;
                end else begin
                    y      <= y + 1'b1;
                    acc_im <= acc_im + step;
                end
            end else begin
                x      <= x + 1'b1;
                acc_re <= acc_re + step;
            end
        end
    end

    assert_step_nonzero_R10: assert property (@(posedge clk) disable iff (rst)
        step != '0) else $error("step reached zero");

    assert_restart_origin_R12: assert property (@(posedge clk) disable iff (rst)
        restart |=> (task_out.x == '0 && task_out.y == '0 && active))
        else $error("restart did not rewind scan");

endmodule

// File: rtl/fd_issue.sv
module fd_issue #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         head_valid,
    input  logic [N-1:0] core_ready,
    output logic [N-1:0] grant
);
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (head_valid && core_ready[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    assert_single_issue_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)) else $error("more than one core granted");

    assert_issue_when_free_R3: assert property (@(posedge clk) disable iff (rst)
        (head_valid && (|core_ready)) |-> (|grant)) else $error("free core left idle");

    for (genvar g = 0; g < N; g++) begin : g_prio
        assert_lowest_ready_R4: assert property (@(posedge clk) disable iff (rst)
            grant[g] |-> (core_ready[g] && ((core_ready & ((N'(1) << g) - N'(1))) == '0)))
            else $error("grant skipped a lower ready core");
    end

endmodule

// File: rtl/fd_collect.sv
module fd_collect
    import fd_pkg::*;
#(
    parameter int N    = 4,
    parameter int HRES = 1024,
    parameter int AW   = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  result_t       head [N],
    output logic [N-1:0]  pop,
    output logic          sram_we,
    output logic [AW-1:0] sram_addr,
    output logic [IW-1:0] sram_wdata
);
    localparam int IDXW = (N > 1) ? $clog2(N) : 1;

    typedef enum logic { W_IDLE, W_WRITE } wstate_e;

    wstate_e         state;
    logic [IDXW-1:0] last, sel;
    logic            any;

    always_comb begin
        int idx;
        any = 1'b0;
        sel = '0;
        for (int k = N - 1; k >= 0; k--) begin
            idx = int'(last) + 1 + k;
            if (idx >= N) idx = idx - N;
            if (req[idx]) begin
                any = 1'b1;
                sel = IDXW'(idx);
            end
        end
    end

    assign pop     = any ? (N'(1) << sel) : '0;
    assign sram_we = (state == W_WRITE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= W_IDLE;
            last       <= IDXW'(N - 1);
            sram_addr  <= '0;
            sram_wdata <= '0;
        end else if (any) begin
            state      <= W_WRITE;
            last       <= sel;
            sram_addr  <= AW'(head[sel].y) * AW'(HRES) + AW'(head[sel].x);
            sram_wdata <= head[sel].iter;
        end else begin
            state <= W_IDLE;
        end
    end

    assert_drain_next_R7: assert property (@(posedge clk) disable iff (rst)
        (|req) |=> sram_we) else $error("pending result not written");

    assert_single_pop_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pop)) else $error("two result fifos taken at once");

    assert_write_has_source_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we) |-> $past(|req)) else $error("write without a result");

endmodule

// File: rtl/fractal_dispatch.sv
module fractal_dispatch
    import fd_pkg::*;
#(
    parameter int     NCORES     = 4,
    parameter int     HRES       = 1024,
    parameter int     VRES       = 768,
    parameter int     TASK_DEPTH = 8,
    parameter int     RES_DEPTH  = 4,
    parameter int     PAN_SHIFT  = 4,
    parameter coord_t INIT_RE    = -36'sd17179869184,
    parameter coord_t INIT_IM    = -36'sd9663676416,
    parameter coord_t INIT_STEP  = 36'sd25165824
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   cmd_valid,
    input  logic [2:0]                             cmd_code,
    output logic [NCORES-1:0]                      core_task_valid,
    output logic [NCORES*$bits(task_t)-1:0]        core_task_data,
    input  logic [NCORES-1:0]                      core_ready,
    input  logic [NCORES-1:0]                      core_res_valid,
    input  logic [NCORES*$bits(result_t)-1:0]      core_res_data,
    output logic [NCORES-1:0]                      core_res_ready,
    output logic                                   sram_we,
    output logic [$clog2(HRES*VRES)-1:0]           sram_addr,
    output logic [IW-1:0]                          sram_wdata
);
    localparam int TASK_W = $bits(task_t);
    localparam int RES_W  = $bits(result_t);
    localparam int AW     = $clog2(HRES * VRES);

    task_t               scan_task;
    logic                scan_push, restart;
    logic [TASK_W-1:0]   tq_head;
    logic                tq_full, tq_empty;
    logic [NCORES-1:0]   grant;
    logic [NCORES-1:0]   rq_full, rq_empty, rq_pop;
    result_t             rq_head [NCORES];

    fd_scan #(
        .HRES(HRES), .VRES(VRES), .PAN_SHIFT(PAN_SHIFT),
        .INIT_RE(INIT_RE), .INIT_IM(INIT_IM), .INIT_STEP(INIT_STEP)
    ) u_scan (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .q_full(tq_full), .push(scan_push), .task_out(scan_task), .restart(restart)
    );

    fd_fifo #(.WIDTH(TASK_W), .DEPTH(TASK_DEPTH)) u_taskq (
        .clk(clk), .rst(rst), .flush(restart),
        .push(scan_push), .din(scan_task),
        .pop(|grant), .dout(tq_head), .full(tq_full), .empty(tq_empty)
    );

    fd_issue #(.N(NCORES)) u_issue (
        .clk(clk), .rst(rst), .head_valid(!tq_empty),
        .core_ready(core_ready), .grant(grant)
    );

    assign core_task_valid = grant;
    assign core_task_data  = {NCORES{tq_head}};
    assign core_res_ready  = ~rq_full;

    for (genvar i = 0; i < NCORES; i++) begin : g_resq
        fd_fifo #(.WIDTH(RES_W), .DEPTH(RES_DEPTH)) u_resq (
            .clk(clk), .rst(rst), .flush(1'b0),
            .push(core_res_valid[i] && !rq_full[i]),
            .din(core_res_data[i*RES_W +: RES_W]),
            .pop(rq_pop[i]), .dout(rq_head[i]),
            .full(rq_full[i]), .empty(rq_empty[i])
        );
    end

    fd_collect #(.N(NCORES), .HRES(HRES), .AW(AW)) u_collect (
        .clk(clk), .rst(rst), .req(~rq_empty), .head(rq_head),
        .pop(rq_pop), .sram_we(sram_we), .sram_addr(sram_addr),
        .sram_wdata(sram_wdata)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!sram_we && core_task_valid == '0)) else $error("activity after reset");

endmodule

// File: tb/fractal_dispatch_test.sv
`timescale 1ns/1ps
module fractal_dispatch_test;
    import fd_pkg::*;

    localparam int     NCORES = 4;
    localparam int     HRES   = 16;
    localparam int     VRES   = 8;
    localparam int     NPIX   = HRES * VRES;
    localparam int     PSH    = 2;
    localparam coord_t I_RE   = -36'sd100;
    localparam coord_t I_IM   = -36'sd50;
    localparam coord_t I_STEP = 36'sd4;
    localparam int     TW     = $bits(task_t);
    localparam int     RW     = $bits(result_t);
    localparam int     AW     = $clog2(NPIX);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_code = 3'd0;
    logic [NCORES-1:0]    core_task_valid, core_ready, core_res_valid, core_res_ready;
    logic [NCORES*TW-1:0] core_task_data;
    logic [NCORES*RW-1:0] core_res_data;
    logic                 sram_we;
    logic [AW-1:0]        sram_addr;
    logic [IW-1:0]        sram_wdata;

    always #4 clk = ~clk;

    fractal_dispatch #(
        .NCORES(NCORES), .HRES(HRES), .VRES(VRES), .TASK_DEPTH(4), .RES_DEPTH(2),
        .PAN_SHIFT(PSH), .INIT_RE(I_RE), .INIT_IM(I_IM), .INIT_STEP(I_STEP)
    ) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .core_task_valid(core_task_valid), .core_task_data(core_task_data),
        .core_ready(core_ready), .core_res_valid(core_res_valid),
        .core_res_data(core_res_data), .core_res_ready(core_res_ready),
        .sram_we(sram_we), .sram_addr(sram_addr), .sram_wdata(sram_wdata)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit fast     = 1'b0;
    bit done     = 1'b0;

    function automatic logic [IW-1:0] iter_of(input logic [XW-1:0] x, input logic [YW-1:0] y);
        return (IW'(x) * 16'd37 + IW'(y) * 16'd113) ^ 16'h5a3c;
    endfunction

    task automatic check(input bit ok, input string req, input string msg);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    // Variable-latency stand-in iteration cores
    for (genvar i = 0; i < NCORES; i++) begin : g_core
        logic          busy, rv, rdy_r;
        logic [2:0]    cnt;
        logic [XW-1:0] sx;
        logic [YW-1:0] sy;
        always @(posedge clk) begin
            if (rst) begin
                busy <= 1'b0; rv <= 1'b0; rdy_r <= 1'b1; cnt <= '0; sx <= '0; sy <= '0;
            end else begin
                rdy_r <= fast ? 1'b1 : (($urandom % 4) != 0);
                if (!busy && core_task_valid[i] && core_ready[i]) begin
                    task_t t;
                    t = task_t'(core_task_data[i*TW +: TW]);
                    busy <= 1'b1;
                    cnt  <= fast ? 3'd0 : 3'($urandom % 6);
                    sx   <= t.x;
                    sy   <= t.y;
                end else if (busy && !rv) begin
                    if (cnt == 0) rv <= 1'b1;
                    else cnt <= cnt - 1'b1;
                end else if (rv && core_res_ready[i]) begin
                    busy <= 1'b0;
                    rv   <= 1'b0;
                end
            end
        end
        assign core_ready[i]           = !busy && rdy_r;
        assign core_res_valid[i]       = rv;
        assign core_res_data[i*RW +: RW] = {sx, sy, iter_of(sx, sy)};
    end

    // Reference view model
    coord_t m_re = I_RE, m_im = I_IM, m_step = I_STEP;
    int exp_x = 0, exp_y = 0, tasks_seen = 0, total_acc = 0, total_wr = 0;
    int wcnt [NPIX];
    logic [IW-1:0] wdat [NPIX];

    function automatic bit cmd_takes(input logic [2:0] c, input coord_t st);
        return (c <= 3'd5) && !(c == 3'd4 && st == coord_t'(1));
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            if (core_task_valid != '0) begin
                logic [NCORES-1:0] low;
                low = '0;
                for (int j = NCORES - 1; j >= 0; j--) if (core_ready[j]) low = NCORES'(1) << j;
                check(core_task_valid == low, "R4",
                      $sformatf("grant %b ready %b expected %b", core_task_valid, core_ready, low));
            end
            for (int i = 0; i < NCORES; i++) begin
                if (core_task_valid[i] && core_ready[i]) begin
                    task_t t;
                    coord_t er, ei;
                    t  = task_t'(core_task_data[i*TW +: TW]);
                    er = m_re + coord_t'(exp_x) * m_step;
                    ei = m_im + coord_t'(exp_y) * m_step;
                    check(int'(t.x) == exp_x && int'(t.y) == exp_y && t.re == er && t.im == ei,
                          (tasks_seen == 0) ? "R12" : "R2",
                          $sformatf("task (%0d,%0d,%0d,%0d) expected (%0d,%0d,%0d,%0d)",
                                    t.x, t.y, t.re, t.im, exp_x, exp_y, er, ei));
                    tasks_seen++;
                    total_acc++;
                    if (exp_x == HRES - 1) begin exp_x = 0; exp_y++; end
                    else exp_x++;
                end
            end
            if (sram_we) begin
                int a;
                a = int'(sram_addr);
                total_wr++;
                check(a < NPIX && sram_wdata == iter_of(XW'(a % HRES), YW'(a / HRES)), "R7",
                      $sformatf("write addr %0d data %h expected %h", a, sram_wdata,
                                iter_of(XW'(a % HRES), YW'(a / HRES))));
                if (a < NPIX) begin wcnt[a]++; wdat[a] = sram_wdata; end
            end
            if (cmd_valid && cmd_takes(cmd_code, m_step)) begin
                coord_t p;
                p = m_step <<< PSH;
                case (cmd_code)
                    3'd0: m_re = m_re - p;
                    3'd1: m_re = m_re + p;
                    3'd2: m_im = m_im - p;
                    3'd3: m_im = m_im + p;
                    3'd4: begin
                        m_re = m_re + m_step * coord_t'(HRES / 4);
                        m_im = m_im + m_step * coord_t'(VRES / 4);
                        m_step = m_step >>> 1;
                    end
                    default: begin
                        m_re = m_re - m_step * coord_t'(HRES / 2);
                        m_im = m_im - m_step * coord_t'(VRES / 2);
                        m_step = m_step <<< 1;
                    end
                endcase
                exp_x = 0; exp_y = 0; tasks_seen = 0;
            end
        end
    end

    task automatic send_cmd(input logic [2:0] c);
        @(posedge clk); #2;
        cmd_valid = 1'b1; cmd_code = c;
        @(posedge clk); #2;
        cmd_valid = 1'b0;
    endtask

    task automatic clear_mem();
        for (int p = 0; p < NPIX; p++) begin wcnt[p] = 0; wdat[p] = '0; end
    endtask

    task automatic wait_frame();
        while (tasks_seen < NPIX) @(posedge clk);
        repeat (40) @(posedge clk);
    endtask

    task automatic check_frame(input string tag);
        for (int p = 0; p < NPIX; p++) begin
            logic [IW-1:0] e;
            e = iter_of(XW'(p % HRES), YW'(p / HRES));
            check(wcnt[p] == 1 && wdat[p] == e, "R8",
                  $sformatf("%s pixel %0d count %0d data %h expected count 1 data %h",
                            tag, p, wcnt[p], wdat[p], e));
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL R8: watchdog expired, actual hung run, expected completion");
        finish_run();
    end

    initial begin
        int seed, a0, w0, cyc;
        seed = $urandom(32'd20517);
        clear_mem();
        // R1: quiet during reset
        repeat (3) begin
            @(negedge clk);
            check(!sram_we && core_task_valid == '0, "R1",
                  $sformatf("we %b valid %b expected 0 0", sram_we, core_task_valid));
        end
        @(posedge clk); #2; rst = 1'b0;

        // R1/R2/R5/R6: first frame from reset view with random core stalls
        wait_frame();
        check_frame("reset frame");

        // R3: all cores free, full throughput
        fast = 1'b1;
        clear_mem();
        send_cmd(3'd1);
        cyc = 0;
        while (tasks_seen < NPIX && cyc < 4000) begin @(posedge clk); cyc++; end
        check(cyc <= NPIX + 12, "R3", $sformatf("frame issue took %0d cycles expected <= %0d", cyc, NPIX + 12));
        repeat (40) @(posedge clk);
        check_frame("pan right");
        fast = 1'b0;

        // R10: zoom in twice (step 4 -> 2 -> 1)
        clear_mem(); send_cmd(3'd4); wait_frame(); check_frame("zoom in");
        send_cmd(3'd4); wait_frame();

        // R10: zoom in at step 1 ignored
        a0 = total_acc; w0 = total_wr;
        send_cmd(3'd4);
        repeat (30) @(posedge clk);
        check(total_acc == a0 && total_wr == w0, "R10",
              $sformatf("tasks %0d writes %0d expected %0d %0d", total_acc, total_wr, a0, w0));

        // R11: unknown codes ignored
        send_cmd(3'd6); send_cmd(3'd7);
        repeat (30) @(posedge clk);
        check(total_acc == a0 && total_wr == w0, "R11",
              $sformatf("tasks %0d writes %0d expected %0d %0d", total_acc, total_wr, a0, w0));

        // R9 + R12: pan up, then pan left mid-frame
        send_cmd(3'd2);
        while (tasks_seen < 40) @(posedge clk);
        send_cmd(3'd0);
        wait_frame();

        // R10 zoom out and R9 pan down, each checked as a full frame
        clear_mem(); send_cmd(3'd5); wait_frame(); check_frame("zoom out");
        clear_mem(); send_cmd(3'd3); wait_frame(); check_frame("pan down");

        finish_run();
    end

endmodule